// File: doc/BRIEF.md
# Serial Bus Talker Byte Transmitter

This block is the transmit side of a peripheral on a three-wire open-collector serial bus with attention, clock and data lines. The device's command decoder raises `start_talk` once it has been told to talk. The block then takes over the clock and data lines, performs the listener-to-talker turnaround and sends bytes one at a time. Each byte comes from a ready/valid source together with a flag that marks the final byte of the stream.

Every bit is clocked out on a fixed schedule set by the talker. Each byte, however, is gated by the listener, which releases DATA when it can take a byte and pulls DATA low to accept a finished frame. The final byte is signalled by a long stall before its first bit. The listener may answer that stall with a DATA pulse, and the block then waits for the pulse to end. A frame that is never acknowledged raises a one-cycle error pulse, and the block returns to waiting for the listener.

All time intervals are counted in pulses of `tick_us`, a one-cycle strobe once per microsecond. Line outputs are active-high pull-down enables. A released line reads back high unless another device pulls it low.

Top module: `serbus_talker`

## Requirements
- R1: After reset, `talking`, `byte_ready` and `frame_err` are low and neither bus line is pulled. Whenever `talking` is low, neither line is pulled.
- R2: After `start_talk`, CLK is not pulled while `bus_clk_in` reads low. Once it reads high, CLK is pulled for exactly TURN_US ticks and then released.
- R3: DATA is pulled during the turnaround hold if and only if `not_found` was high when `start_talk` was seen. DATA is released once the hold ends.
- R4: `byte_ready` is high only in the ready-to-send step while `bus_data_in` reads high, and never during a byte transfer. A byte is taken on a cycle where `byte_ready` and `byte_valid` are both high.
- R5: For a byte with `byte_last` low, the first CLK pull of its bits comes exactly RFD_US ticks after the byte is taken.
- R6: For a byte with `byte_last` high, the block waits EOI_WAIT_US ticks. If DATA reads high at the end of that wait, bit transfer starts at once.
- R7: If DATA reads low at the end of the final-byte wait, bit transfer starts only when DATA reads high and at least EOI_HOLD_US ticks have passed since the wait ended. CLK stays released until then.
- R8: Each bit cell pulls CLK with DATA released for SETUP_US ticks. It then releases CLK with the DATA line equal to the bit value (released for 1, pulled for 0) for VALID_US ticks. Eight bits are sent, least significant bit first.
- R9: After the eighth bit, CLK is pulled and DATA is released. When the listener pulls DATA low on a non-final byte, CLK is released and the block returns to the ready-to-send step.
- R10: When a final byte is acknowledged, both lines are released and `talking` falls.
- R11: If DATA is not pulled within ACK_US ticks after the eighth bit, `frame_err` is high for one cycle. Both lines are released and the block returns to the ready-to-send step, where it takes the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| start_talk | input | 1 | Pulse: device commanded to talk |
| not_found | input | 1 | Error pending; signalled during turnaround |
| byte_data | input | 8 | Byte to send |
| byte_last | input | 1 | Byte is the final one of the stream |
| byte_valid | input | 1 | Byte source has a byte |
| byte_ready | output | 1 | Block takes the byte this cycle if valid |
| bus_clk_in | input | 1 | CLK line readback, high when released |
| bus_data_in | input | 1 | DATA line readback, high when released |
| bus_clk_pull | output | 1 | Pull CLK line low |
| bus_data_pull | output | 1 | Pull DATA line low |
| talking | output | 1 | Block owns the bus as talker |
| frame_err | output | 1 | One-cycle pulse on missing frame acknowledge |

## Verification
The bench builds the block with short intervals: TURN_US 8, RFD_US 4, EOI_WAIT_US 30, EOI_HOLD_US 6, SETUP_US 7, VALID_US 5 and ACK_US 40, with a tick every third clock. These values let every phase be measured to the exact tick count. The acknowledge timeout and the final-byte stall also fit many times into one run, which covers all three final-byte outcomes: no pulse, a long pulse and a pulse released early. It also covers frame errors mixed between ordinary bytes and a turnaround with and without a pending error.

// File: rtl/serbus_talker.sv
module serbus_talker #(
  parameter int unsigned TURN_US     = 80,
  parameter int unsigned RFD_US      = 40,
  parameter int unsigned EOI_WAIT_US = 350,
  parameter int unsigned EOI_HOLD_US = 60,
  parameter int unsigned SETUP_US    = 70,
  parameter int unsigned VALID_US    = 60,
  parameter int unsigned ACK_US      = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       start_talk,
  input  logic       not_found,
  input  logic [7:0] byte_data,
  input  logic       byte_last,
  input  logic       byte_valid,
  output logic       byte_ready,
  input  logic       bus_clk_in,
  input  logic       bus_data_in,
  output logic       bus_clk_pull,
  output logic       bus_data_pull,
  output logic       talking,
  output logic       frame_err
);
  localparam int unsigned SUM = TURN_US + RFD_US + EOI_WAIT_US + EOI_HOLD_US
                              + SETUP_US + VALID_US + ACK_US;
  localparam int TW = $clog2(SUM + 1);
  localparam logic [TW-1:0] T_TURN = TW'(TURN_US);
  localparam logic [TW-1:0] T_RFD  = TW'(RFD_US);
  localparam logic [TW-1:0] T_EOIW = TW'(EOI_WAIT_US);
  localparam logic [TW-1:0] T_EOIH = TW'(EOI_HOLD_US);
  localparam logic [TW-1:0] T_SET  = TW'(SETUP_US);
  localparam logic [TW-1:0] T_VAL  = TW'(VALID_US);
  localparam logic [TW-1:0] T_ACK  = TW'(ACK_US);

  typedef enum logic [3:0] {
    S_IDLE, S_TURN_WAIT, S_TURN_HOLD, S_RTS, S_RFD,
    S_EOI_LOW, S_BIT_SET, S_BIT_VAL, S_ACK
  } st_t;

  st_t st;
  logic [TW-1:0] tmr;
  logic [7:0] sh;
  logic [2:0] bit_idx;
  logic last_q, nf_q;
  logic done;

  assign done          = (tmr == '0);
  assign talking       = (st != S_IDLE);
  assign byte_ready    = (st == S_RTS) && bus_data_in;
  assign bus_clk_pull  = (st == S_TURN_HOLD) || (st == S_BIT_SET) || (st == S_ACK);
  assign bus_data_pull = ((st == S_TURN_HOLD) && nf_q) || ((st == S_BIT_VAL) && !sh[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      sh        <= '0;
      bit_idx   <= '0;
      last_q    <= 1'b0;
      nf_q      <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (tick_us && !done) tmr <= tmr - 1'b1;
      unique case (st)
        S_IDLE:
          if (start_talk) begin
            nf_q <= not_found;
            st   <= S_TURN_WAIT;
          end
        S_TURN_WAIT:
          if (bus_clk_in) begin
            tmr <= T_TURN;
            st  <= S_TURN_HOLD;
          end
        S_TURN_HOLD:
          if (done) st <= S_RTS;
        S_RTS:
          if (bus_data_in && byte_valid) begin
            sh     <= byte_data;
            last_q <= byte_last;
            tmr    <= byte_last ? T_EOIW : T_RFD;
            st     <= S_RFD;
          end
        S_RFD:
          if (done) begin
            if (last_q && !bus_data_in) begin
              tmr <= T_EOIH;
              st  <= S_EOI_LOW;
            end else begin
              tmr     <= T_SET;
              bit_idx <= '0;
              st      <= S_BIT_SET;
            end
          end
        S_EOI_LOW:
          if (done && bus_data_in) begin
            tmr     <= T_SET;
            bit_idx <= '0;
            st      <= S_BIT_SET;
          end
        S_BIT_SET:
          if (done) begin
            tmr <= T_VAL;
            st  <= S_BIT_VAL;
          end
        S_BIT_VAL:
          if (done) begin
            sh <= sh >> 1;
            if (bit_idx == 3'd7) begin
              tmr <= T_ACK;
              st  <= S_ACK;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              tmr     <= T_SET;
              st      <= S_BIT_SET;
            end
          end
        S_ACK:
          if (!bus_data_in) begin
            st <= last_q ? S_IDLE : S_RTS;
          end else if (done) begin
            frame_err <= 1'b1;
            st        <= S_RTS;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serbus_talker_chk.sv
module serbus_talker_chk (
  input logic clk,
  input logic rst_n,
  input logic talking,
  input logic byte_ready,
  input logic byte_valid,
  input logic bus_data_in,
  input logic bus_clk_pull,
  input logic bus_data_pull,
  input logic frame_err
);
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !talking |-> (!bus_clk_pull && !bus_data_pull));

  assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (bus_data_in && !bus_clk_pull && talking));

  assert_take_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready && byte_valid) |=> !byte_ready);

  assert_end_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(talking) |-> $past(!bus_data_in));

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_err_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!bus_clk_pull && !bus_data_pull && talking));
endmodule

bind serbus_talker serbus_talker_chk i_chk (
  .clk(clk), .rst_n(rst_n), .talking(talking), .byte_ready(byte_ready),
  .byte_valid(byte_valid), .bus_data_in(bus_data_in), .bus_clk_pull(bus_clk_pull),
  .bus_data_pull(bus_data_pull), .frame_err(frame_err)
);

// File: tb/test_serbus_talker.sv
module test_serbus_talker;
  localparam int P_TURN = 8, P_RFD = 4, P_EOIW = 30, P_EOIH = 6;
  localparam int P_SET = 7, P_VAL = 5, P_ACK = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic tick_us;
  logic start_talk = 1'b0, not_found = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_last = 1'b0, byte_valid = 1'b0;
  logic byte_ready, bus_clk_pull, bus_data_pull, talking, frame_err;
  logic ctl_clk = 1'b1, lst = 1'b1;
  logic clk_line, data_line;

  always_ff @(posedge clk) tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
  assign tick_us   = (tdiv == 2'd2);
  assign clk_line  = !(ctl_clk || bus_clk_pull);
  assign data_line = !(lst || bus_data_pull);

  serbus_talker #(
    .TURN_US(P_TURN), .RFD_US(P_RFD), .EOI_WAIT_US(P_EOIW), .EOI_HOLD_US(P_EOIH),
    .SETUP_US(P_SET), .VALID_US(P_VAL), .ACK_US(P_ACK)
  ) i_serbus_talker (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start_talk(start_talk),
    .not_found(not_found), .byte_data(byte_data), .byte_last(byte_last),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .bus_clk_in(clk_line),
    .bus_data_in(data_line), .bus_clk_pull(bus_clk_pull), .bus_data_pull(bus_data_pull),
    .talking(talking), .frame_err(frame_err)
  );

  int checks = 0, errors = 0, rdy_bad = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ticks from byte taken to first CLK pull; eoi mode 0 none, 1 long pulse, 2 early release
  function automatic int exp_gap(input logic last, input int mode);
    if (!last) return P_RFD;
    if (mode == 0) return P_EOIW;
    if (mode == 1) return P_EOIW + P_EOIH + 3;
    return P_EOIW + P_EOIH;
  endfunction

  task automatic count_pull(input logic want, output int n);
    n = 0;
    while (bus_clk_pull == want) begin
      if (byte_ready) rdy_bad++;
      if (tick_us) n++;
      @(negedge clk);
    end
  endtask

  task automatic turnaround(input logic nf);
    int n;
    ctl_clk = 1'b1; lst = 1'b1; not_found = nf; start_talk = 1'b1;
    @(negedge clk);
    start_talk = 1'b0;
    chk(talking == 1'b1, "R2 talking after start", talking, 1);
    repeat (5) @(negedge clk);
    chk(bus_clk_pull == 1'b0, "R2 no pull while CLK held", bus_clk_pull, 0);
    ctl_clk = 1'b0;
    @(negedge clk);
    chk(bus_clk_pull == 1'b1, "R2 CLK pulled on turnaround", bus_clk_pull, 1);
    chk(bus_data_pull == nf, "R3 DATA during hold", bus_data_pull, nf);
    count_pull(1'b1, n);
    chk(n == P_TURN, "R2 turnaround hold ticks", n, P_TURN);
    chk(bus_data_pull == 1'b0, "R3 DATA released after hold", bus_data_pull, 0);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last, input int eoi_mode,
                           input logic ack, input logic keep_valid);
    int n, ns, nv;
    logic pulled, released;
    logic [7:0] rx;
    rdy_bad = 0;
    byte_data = d; byte_last = last; byte_valid = 1'b1;
    #1;
    chk(byte_ready == 1'b0, "R4 not ready while DATA held", byte_ready, 0);
    lst = 1'b0;
    #1;
    chk(byte_ready == 1'b1, "R4 ready when DATA released", byte_ready, 1);
    @(negedge clk);
    if (keep_valid) byte_data = ~d; else byte_valid = 1'b0;
    n = 0; pulled = 1'b0; released = 1'b0;
    while (!bus_clk_pull) begin
      if (byte_ready) rdy_bad++;
      if (tick_us) n++;
      if (last && eoi_mode != 0 && !pulled && n == P_EOIW - 4) begin
        lst = 1'b1; pulled = 1'b1;
      end
      if (pulled && !released &&
          ((eoi_mode == 1 && n == P_EOIW + P_EOIH + 3) || (eoi_mode == 2 && n == P_EOIW + 2))) begin
        lst = 1'b0; released = 1'b1;
      end
      @(negedge clk);
    end
    if (!last) chk(n == exp_gap(last, eoi_mode), "R5 gap before bits", n, exp_gap(last, eoi_mode));
    else if (eoi_mode == 0) chk(n == exp_gap(last, eoi_mode), "R6 final wait no pulse", n, exp_gap(last, eoi_mode));
    else chk(n == exp_gap(last, eoi_mode), "R7 final wait with pulse", n, exp_gap(last, eoi_mode));
    rx = 8'h00;
    for (int i = 0; i < 8; i++) begin
      count_pull(1'b1, ns);
      if (i == 0 || ns != P_SET) chk(ns == P_SET, "R8 setup ticks", ns, P_SET);
      rx[i] = data_line;
      count_pull(1'b0, nv);
      if (i == 0 || nv != P_VAL) chk(nv == P_VAL, "R8 valid ticks", nv, P_VAL);
    end
    chk(rx == d, "R8 byte LSB first", rx, d);
    chk(rdy_bad == 0, "R4 no ready during transfer", rdy_bad, 0);
    chk(bus_clk_pull && !bus_data_pull, "R9 CLK pulled DATA released after bits",
        {bus_clk_pull, bus_data_pull}, 2);
    byte_valid = 1'b0;
    if (ack) begin
      repeat (3) @(negedge clk);
      lst = 1'b1;
      @(negedge clk);
      chk(frame_err == 1'b0, "R9 no error on ack", frame_err, 0);
      if (last)
        chk(!talking && !bus_clk_pull && !bus_data_pull, "R10 released after final ack",
            {talking, bus_clk_pull, bus_data_pull}, 0);
      else
        chk(talking && !bus_clk_pull && !byte_ready, "R9 back to ready-to-send",
            {talking, bus_clk_pull, byte_ready}, 4);
    end else begin
      n = 0;
      while (!frame_err) begin
        if (tick_us) n++;
        @(negedge clk);
      end
      chk(n == P_ACK, "R11 ack timeout ticks", n, P_ACK);
      chk(!bus_clk_pull && !bus_data_pull, "R11 lines released", {bus_clk_pull, bus_data_pull}, 0);
      @(negedge clk);
      chk(frame_err == 1'b0, "R11 error one cycle", frame_err, 0);
      lst = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (4) @(negedge clk);
    chk(!talking && !byte_ready && !frame_err && !bus_clk_pull && !bus_data_pull,
        "R1 reset state", {talking, byte_ready, frame_err, bus_clk_pull, bus_data_pull}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!talking && !bus_clk_pull && !bus_data_pull, "R1 idle after reset",
        {talking, bus_clk_pull, bus_data_pull}, 0);

    turnaround(1'b1);
    send_byte(8'hA5, 1'b0, 0, 1'b1, 1'b0);
    send_byte(8'h01, 1'b0, 0, 1'b1, 1'b1);
    send_byte(8'h3C, 1'b0, 0, 1'b0, 1'b0);
    send_byte(8'h80, 1'b0, 0, 1'b1, 1'b0);
    send_byte(8'hFF, 1'b1, 1, 1'b1, 1'b0);
    chk(talking == 1'b0, "R10 session ends", talking, 0);

    turnaround(1'b0);
    for (int k = 0; k < 14; k++) begin
      logic [7:0] rb;
      rb = 8'($urandom);
      send_byte(rb, 1'b0, 0, ($urandom % 5) != 0, ($urandom % 2) != 0);
    end
    send_byte(8'h00, 1'b1, 0, 1'b1, 1'b0);

    turnaround(1'b0);
    send_byte(8'h5A, 1'b0, 0, 1'b0, 1'b0);
    send_byte(8'hC3, 1'b1, 2, 1'b1, 1'b0);
    chk(!talking && !bus_clk_pull && !bus_data_pull, "R1 idle after final byte",
        {talking, bus_clk_pull, bus_data_pull}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule